// File: doc/BRIEF.md
# Serial Path-Overhead Insertion Stage

This block is the last stage of a bit-serial transmit path that builds a cell-carrying frame with nine bytes of path overhead per frame. An upstream stage presents the stream one bit per clock, marks which bits belong to path overhead, and flags the first overhead bit of each frame. The block passes payload bits through untouched. For every overhead bit it offers a slot to an external device on a small serial port, and lets that device take over the bit.

The overhead bytes follow the frame's row order: Z3, Z2, Z1, F1, B1, G1, M2, M1, C1. For most bytes, an asserted enable makes the external data bit replace the internal bit. The two checksum-style bytes, B1 and C1, work differently: the external bit is an error mask and is XORed into the bit produced upstream. External insertion has the last word over every value made earlier in the path, including error insertion. With the enable held low, the stage is a plain two-cycle delay.

The block counts overhead bits itself to know which byte each slot falls in. A frame-start flag on an overhead bit forces the count back to bit 0 (the MSB) of Z3. It also raises a frame-start strobe on the port, so the external device can align its own bit count.

Top module: `ohi_serial_insert`

## Requirements
- R1: While reset is high and in the cycle after it, `out_vld`, `ext_slot` and `ext_sof` are low.
- R2: With `ext_en` low, `out_bit`, `out_vld`, `out_oh` and `out_sof` equal `in_bit`, `in_vld`, `in_oh` and `in_sof` from two clock edges earlier.
- R3: A bit that is not overhead (`in_oh` low) reaches `out_bit` unchanged, whatever `ext_en` and `ext_dat` do while it is in the stage.
- R4: `ext_slot` is high in exactly the cycle after the edge that accepts a valid overhead bit (`in_vld` and `in_oh` both high), and low otherwise. `ext_en` and `ext_dat` are sampled in that cycle.
- R5: In a slot with `ext_en` high that falls in any byte other than B1 and C1, the output bit is `ext_dat`.
- R6: In a slot with `ext_en` high that falls in B1 (byte index 4) or C1 (byte index 8), the output bit is the internal bit XOR `ext_dat`.
- R7: Overhead bits are numbered from 0 within a frame. Bit n belongs to byte n/8, with the bytes in the order Z3, Z2, Z1, F1, B1, G1, M2, M1, C1 (indices 0 to 8), and is sent MSB first. A valid overhead bit with `in_sof` high is bit 0. `ext_sof` is high together with `ext_slot` for that bit. After bit 71 the count wraps to 0 even if no frame-start flag arrives.
- R8: A clock with `in_vld` low carries no bit. It raises no slot, does not move the overhead count, and gives `out_vld` low two edges later.
- R9: A frame-start flag arriving in the middle of a frame puts the count back to bit 0 of Z3 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Incoming stream bit |
| in_vld | input | 1 | `in_bit` carries a bit this cycle |
| in_oh | input | 1 | Incoming bit is a path-overhead bit |
| in_sof | input | 1 | Incoming bit is the first overhead bit of a frame |
| ext_dat | input | 1 | External overhead data bit, sampled during `ext_slot` |
| ext_en | input | 1 | External insertion enable, sampled during `ext_slot` |
| ext_slot | output | 1 | Overhead bit time strobe for the external device |
| ext_sof | output | 1 | Strobe for the first overhead bit (Z3 MSB) of a frame |
| out_bit | output | 1 | Outgoing stream bit |
| out_vld | output | 1 | `out_bit` carries a bit |
| out_oh | output | 1 | Outgoing bit is a path-overhead bit |
| out_sof | output | 1 | Outgoing bit is the first overhead bit of a frame |

## Verification
The assertions check several rules on every cycle. They check the timing of the slot strobe against accepted overhead bits and the two-edge delay of the valid flag. They check that payload bits pass through unchanged, and the choice between replace and XOR inside a slot, using the byte class the counter reports. Only the bench's scenarios can show that the byte class itself is right. They cover the Z3-to-C1 numbering, wrap-around without a frame-start flag, re-alignment on a mid-frame flag, and counting that skips idle clocks. The bench checks these against its own bit count over frames with gaps, all enable and data patterns, and every byte position.

// File: rtl/ohi_pkg.sv
package ohi_pkg;

  // one stream beat as it moves through the stage
  typedef struct packed {
    logic dat;
    logic vld;
    logic oh;
    logic sof;
  } ohi_beat_t;

  // default overhead layout: nine bytes of eight bits
  localparam int unsigned OHI_BYTES  = 9;
  localparam int unsigned OHI_BYTE_W = 8;

  // bytes handled as XOR masks: B1 (index 4) and C1 (index 8)
  localparam logic [OHI_BYTES-1:0] OHI_XOR_MASK = 9'b1_0001_0000;

endpackage

// File: rtl/ohi_oh_counter.sv
module ohi_oh_counter #(
  parameter int unsigned OH_BYTES = 9,
  parameter int unsigned BYTE_W   = 8,
  localparam int unsigned BYTE_CW = (OH_BYTES > 1) ? $clog2(OH_BYTES) : 1,
  localparam int unsigned BIT_CW  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              sof,
  output logic [BYTE_CW-1:0] cur_byte,
  output logic [BIT_CW-1:0]  cur_bit
);

  localparam logic [BYTE_CW-1:0] LAST_BYTE = BYTE_CW'(OH_BYTES - 1);
  localparam logic [BIT_CW-1:0]  LAST_BIT  = BIT_CW'(BYTE_W - 1);

  logic [BYTE_CW-1:0] byte_q;
  logic [BIT_CW-1:0]  bit_q;

  // a frame start forces this bit to be the first of the first byte
  always_comb begin
    cur_byte = sof ? '0 : byte_q;
    cur_bit  = sof ? '0 : bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      bit_q  <= '0;
    end else if (adv) begin
      if (cur_bit == LAST_BIT) begin
        bit_q  <= '0;
        byte_q <= (cur_byte == LAST_BYTE) ? '0 : cur_byte + 1'b1;
      end else begin
        bit_q  <= cur_bit + 1'b1;
        byte_q <= cur_byte;
      end
    end
  end

endmodule

// File: rtl/ohi_bit_mix.sv
module ohi_bit_mix (
  input  logic int_bit,
  input  logic slot,
  input  logic xor_sel,
  input  logic ext_en,
  input  logic ext_dat,
  output logic mix_bit
);

  always_comb begin
    if (slot && ext_en)
      mix_bit = xor_sel ? (int_bit ^ ext_dat) : ext_dat;
    else
      mix_bit = int_bit;
  end

endmodule

// File: rtl/ohi_serial_insert.sv
module ohi_serial_insert
  import ohi_pkg::*;
#(
  parameter int unsigned           OH_BYTES = OHI_BYTES,
  parameter int unsigned           BYTE_W   = OHI_BYTE_W,
  parameter logic [OH_BYTES-1:0]   XOR_MASK = OHI_XOR_MASK
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_vld,
  input  logic in_oh,
  input  logic in_sof,
  input  logic ext_dat,
  input  logic ext_en,
  output logic ext_slot,
  output logic ext_sof,
  output logic out_bit,
  output logic out_vld,
  output logic out_oh,
  output logic out_sof
);

  localparam int unsigned BYTE_CW = (OH_BYTES > 1) ? $clog2(OH_BYTES) : 1;
  localparam int unsigned BIT_CW  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  ohi_beat_t s1_q;
  ohi_beat_t s2_q;

  // stage 1: capture the incoming beat; the data bit carries no reset
  always_ff @(posedge clk) begin
    s1_q.dat <= in_bit;
    if (rst) begin
      s1_q.vld <= 1'b0;
      s1_q.oh  <= 1'b0;
      s1_q.sof <= 1'b0;
    end else begin
      s1_q.vld <= in_vld;
      s1_q.oh  <= in_oh;
      s1_q.sof <= in_sof;
    end
  end

  logic slot;
  assign slot     = s1_q.vld & s1_q.oh;
  assign ext_slot = slot;
  assign ext_sof  = slot & s1_q.sof;

  logic [BYTE_CW-1:0] cur_byte;
  logic [BIT_CW-1:0]  cur_bit;

  ohi_oh_counter #(
    .OH_BYTES (OH_BYTES),
    .BYTE_W   (BYTE_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .adv      (slot),
    .sof      (s1_q.sof),
    .cur_byte (cur_byte),
    .cur_bit  (cur_bit)
  );

  // per-byte match against the XOR set
  logic [OH_BYTES-1:0] byte_hit;
  for (genvar g = 0; g < OH_BYTES; g++) begin : g_xor
    if (XOR_MASK[g]) begin : g_on
      assign byte_hit[g] = (cur_byte == BYTE_CW'(g));
    end else begin : g_off
      assign byte_hit[g] = 1'b0;
    end
  end

  logic xor_sel;
  logic mix_bit;
  logic unused_bit;
  assign xor_sel    = |byte_hit;
  assign unused_bit = ^cur_bit;

  ohi_bit_mix u_mix (
    .int_bit (s1_q.dat),
    .slot    (slot),
    .xor_sel (xor_sel),
    .ext_en  (ext_en),
    .ext_dat (ext_dat),
    .mix_bit (mix_bit)
  );

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    s2_q.dat <= mix_bit;
    if (rst) begin
      s2_q.vld <= 1'b0;
      s2_q.oh  <= 1'b0;
      s2_q.sof <= 1'b0;
    end else begin
      s2_q.vld <= s1_q.vld;
      s2_q.oh  <= s1_q.oh;
      s2_q.sof <= s1_q.sof;
    end
  end

  assign out_bit = s2_q.dat;
  assign out_vld = s2_q.vld;
  assign out_oh  = s2_q.oh;
  assign out_sof = s2_q.sof;

endmodule

// File: rtl/ohi_serial_insert_chk.sv
module ohi_serial_insert_chk (
  input logic clk,
  input logic rst,
  input logic in_bit,
  input logic in_vld,
  input logic in_oh,
  input logic ext_dat,
  input logic ext_en,
  input logic ext_slot,
  input logic ext_sof,
  input logic out_bit,
  input logic out_vld,
  input logic cur_xor
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && !ext_slot && !ext_sof));

  // R4
  slot_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_oh) |=> ext_slot);

  // R4
  slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_vld && in_oh) |=> !ext_slot);

  // R7
  sof_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ext_sof |-> ext_slot);

  // R8
  vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 out_vld);

  // R8
  idle_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ##1 !out_vld);

  // R3
  payload_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_oh) |=> ##1 (out_bit == $past(in_bit, 2)));

  // R2
  no_en_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_slot && !ext_en) |=> (out_bit == $past(in_bit, 2)));

  // R5
  replace_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_slot && ext_en && !cur_xor) |=> (out_bit == $past(ext_dat)));

  // R6
  xor_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_slot && ext_en && cur_xor) |=> (out_bit == ($past(in_bit, 2) ^ $past(ext_dat))));

endmodule

bind ohi_serial_insert ohi_serial_insert_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_bit   (in_bit),
  .in_vld   (in_vld),
  .in_oh    (in_oh),
  .ext_dat  (ext_dat),
  .ext_en   (ext_en),
  .ext_slot (ext_slot),
  .ext_sof  (ext_sof),
  .out_bit  (out_bit),
  .out_vld  (out_vld),
  .cur_xor  (xor_sel)
);

// File: tb/ohi_serial_insert_tb_top.sv
`timescale 1ns/1ps
module ohi_serial_insert_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0, in_vld = 1'b0, in_oh = 1'b0, in_sof = 1'b0;
  logic ext_dat = 1'b0, ext_en = 1'b0;
  logic ext_slot, ext_sof, out_bit, out_vld, out_oh, out_sof;

  always #2.5 clk = ~clk;

  ohi_serial_insert dut_i (
    .clk(clk), .rst(rst),
    .in_bit(in_bit), .in_vld(in_vld), .in_oh(in_oh), .in_sof(in_sof),
    .ext_dat(ext_dat), .ext_en(ext_en),
    .ext_slot(ext_slot), .ext_sof(ext_sof),
    .out_bit(out_bit), .out_vld(out_vld), .out_oh(out_oh), .out_sof(out_sof)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [15:0] lf = 16'hACE1;
  string scn_tag = "";

  // bench frame model
  int m_idx = 0;
  logic p1_b = 0, p1_v = 0, p1_oh = 0, p1_sof = 0;
  logic e_b = 0, e_v = 0, e_oh = 0, e_sof = 0;
  string e_tag = "R2";

  task automatic rnd(output logic r);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    r  = lf[0];
  endtask

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: check, drive ext for the beat in stage 1, drive next input
  task automatic step(input logic nb, input logic nv, input logic noh, input logic nsof,
                      input logic en, input logic dat);
    logic slot, xb, ob;
    int idx, byt;
    string t;
    slot = p1_v & p1_oh;
    chk("R4", ext_slot, slot, "ext_slot");
    chk((scn_tag != "") ? scn_tag : "R7", ext_sof, slot & p1_sof, "ext_sof");
    chk("R8", out_vld, e_v, "out_vld");
    if (e_v) begin
      chk(e_tag, out_bit, e_b, "out_bit");
      chk("R2", out_oh, e_oh, "out_oh");
      chk("R2", out_sof, e_sof, "out_sof");
    end
    ext_en  = en;
    ext_dat = dat;
    ob = p1_b;
    t  = en ? "R3" : "R2";
    if (slot) begin
      idx   = p1_sof ? 0 : m_idx;
      byt   = idx / 8;
      xb    = (byt == 4) || (byt == 8);
      m_idx = (idx == 71) ? 0 : idx + 1;
      if (en) begin
        ob = xb ? (p1_b ^ dat) : dat;
        t  = xb ? "R6" : "R5";
      end else t = "R2";
    end
    if (scn_tag != "" && slot) t = scn_tag;
    e_b = ob; e_v = p1_v; e_oh = p1_oh; e_sof = p1_sof; e_tag = t;
    p1_b = nb; p1_v = nv; p1_oh = noh; p1_sof = nsof;
    in_bit = nb; in_vld = nv; in_oh = noh; in_sof = nsof;
    @(negedge clk);
  endtask

  // mode 0: enable low, 1: enable always high, 2: random enable
  task automatic frame(input bit do_sof, input int rows, input int mode, input bit gaps);
    logic b, e, d, g, o;
    for (int r = 0; r < rows; r++) begin
      for (int k = 0; k < 16; k++) begin
        if (gaps) begin
          rnd(g);
          if (g) begin
            rnd(b); rnd(o); rnd(d);
            step(b, 1'b0, o, 1'b0, (mode == 1), d);
          end
        end
        rnd(b); rnd(d); rnd(e);
        e = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : e;
        step(b, 1'b1, (k < 8), (do_sof && r == 0 && k == 0), e, d);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    in_vld = 1'b1; in_oh = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", out_vld, 1'b0, "out_vld in reset");
    chk("R1", ext_slot, 1'b0, "ext_slot in reset");
    in_vld = 1'b0; in_oh = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", out_vld, 1'b0, "out_vld after reset");
    chk("R1", ext_slot, 1'b0, "ext_slot after reset");
    chk("R1", ext_sof, 1'b0, "ext_sof after reset");

    // R2 and R8: pass-through with idle gaps
    frame(1'b1, 9, 0, 1'b1);
    frame(1'b1, 9, 0, 1'b1);
    // R3, R5, R6: enable held high everywhere
    frame(1'b1, 9, 1, 1'b0);
    frame(1'b1, 9, 1, 1'b1);
    // sweep of enable and data patterns over every byte
    for (int f = 0; f < 6; f++) frame(1'b1, 9, 2, f[0]);
    // R7: wrap after bit 71 with no frame-start flag
    scn_tag = "R7";
    frame(1'b1, 9, 2, 1'b0);
    frame(1'b0, 9, 2, 1'b1);
    frame(1'b0, 9, 1, 1'b0);
    // R9: frame start in the middle of a frame
    scn_tag = "R9";
    frame(1'b1, 4, 1, 1'b0);
    frame(1'b1, 9, 1, 1'b1);
    frame(1'b1, 2, 2, 1'b0);
    frame(1'b1, 9, 2, 1'b0);
    scn_tag = "";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule